// File: doc/BRIEF.md
# Asynchronous Schedule Idle Detector

This block walks the circular ring of queue heads that makes up a USB 2.0 host controller's asynchronous schedule. It works out when a full lap of the ring has gone by without any transaction being carried out. It needs no counter and no end-of-list pointer to do this. It keeps a single reclamation flag and relies on software having marked exactly one queue head in the ring as the list head. Every transaction that executes sets the flag. Every fetch of the marked queue head clears it. If the marked queue head is reached while the flag is already clear, one whole lap has passed with no work done, and the walk stops.

The walker has a simple request/valid read port for fetching queue head words. For each queue head it visits, it offers a one-cycle execution slot to an external transaction engine, which answers by reporting whether a transaction ran. A micro-frame start pulse drives an internal countdown of the cycles left in the current micro-frame. Once stopped, the walker can be restarted before the micro-frame ends if enough cycles remain, and it then resumes from where it stopped. A doorbell handshake tells software when queue heads unlinked from the ring may safely be reused.

Top module: `async_idle_detect`

## Requirements
- R1: After reset, reclFlag, travActive, idle, asyncAdvSts, memReq and execReq are all 0.
- R2: Entry addresses are 32-byte aligned. The link word is read first, at the entry address. In it, bits 31:5 hold the next entry address divided by 32, bits 2:1 hold the entry type (01 = queue head), and bit 0 is terminate. The second word is read at entry address + 4, and its bit 15 is the head-of-list mark. Queue heads are offered for execution in ring order, with execQhAddr equal to the entry address.
- R3: While schedEnable is low the walker is off. When it is high and the walker is off, the walker loads listBase, sets reclFlag to 1 on the next edge, and starts fetching at listBase.
- R4: Fetching a marked second word while reclFlag is 1 clears reclFlag. The walk then continues and that queue head is offered.
- R5: txnExec high during an execution offer (execReq) sets reclFlag on that edge.
- R6: Fetching a marked second word while reclFlag is 0 stops the walk. idle goes to 1, travActive goes to 0, and no further fetches or offers occur. With the mark on the entry at index 0, a ring of n entries started at index b makes (n-b) mod n offers and then whole laps of n, and it stops after the first lap that contains no executed transaction.
- R7: An entry whose type is not 01 is not offered, and its second word is not fetched. The walk follows that entry's link pointer.
- R8: A link word with terminate set stops the walk, with idle set to 1.
- R9: A uframeStart pulse while stopped restarts the walk. The restart begins at the entry where the walk stopped, not at listBase, and sets reclFlag to 1.
- R10: uframeStart reloads the cycle countdown to UF_LEN-1, and the countdown then decreases by one every cycle down to 0. While stopped, kickRestart restarts the walk only if the countdown is at least MIN_LEFT. Otherwise it is ignored and idle stays 1.
- R11: A doorbell arms a pending request. asyncAdvSts is never set on the edge that samples the doorbell. If the walk is not active, asyncAdvSts is set on the following edge. If the walk is active, it is set when the current execution offer completes.
- R12: asyncAdvSts stays at 1 until a clrAdvance pulse clears it. A doorbell that arrives while it is 1 is ignored.
- R13: Dropping schedEnable switches the walker off on the next edge, with travActive, idle and memReq all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| schedEnable | input | 1 | Asynchronous schedule enable |
| listBase | input | AW | Address of the first entry to walk |
| memReq | output | 1 | Read request, held until memValid |
| memAddr | output | AW | Read address |
| memValid | input | 1 | Read data valid |
| memData | input | DW | Read data |
| execReq | output | 1 | Execution offer for the current queue head |
| execQhAddr | output | AW | Address of the offered queue head |
| txnExec | input | 1 | Engine ran a transaction during the offer |
| uframeStart | input | 1 | Micro-frame start pulse |
| kickRestart | input | 1 | Request to restart an idle walk early |
| doorbell | input | 1 | Async-advance doorbell |
| clrAdvance | input | 1 | Write-one-to-clear for asyncAdvSts |
| reclFlag | output | 1 | Reclamation flag |
| travActive | output | 1 | Walk in progress |
| idle | output | 1 | Walk stopped on an empty lap or a terminate |
| asyncAdvSts | output | 1 | Safe-to-reuse status |

## Verification
The bench sweeps ring sizes, start positions and transaction budgets. It targets the count of laps before the stop, which a design that clears or sets the flag on the wrong event would get wrong by a whole lap, or would never reach at all. It restarts with a start index other than zero, so a design that reloads the list base on a restart offers the wrong first address. It probes the restart window at exactly MIN_LEFT and at one cycle less, to catch an off-by-one comparison. It checks that the doorbell status does not appear in the same cycle as the doorbell, and that a second doorbell is not silently re-armed while the status is set.

// File: rtl/asedPkg.sv
package asedPkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LINK,
    ST_HEAD,
    ST_EXEC,
    ST_STOP
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;
    logic latchLink;
    logic stepMem;
    logic stepLatch;
    logic setRecl;
    logic clrRecl;
    logic hiWord;
  } dpStrobe_t;

  // decoded fields and flag returned to control
  typedef struct packed {
    logic linkTerm;
    logic linkIsQh;
    logic headBit;
    logic reclFlag;
  } dpStatus_t;

  localparam logic [1:0] TYPE_QH = 2'b01;

endpackage

// File: rtl/async_idle_dp.sv
module async_idle_dp
  import asedPkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PTR_LSB    = 5,
  parameter int HEAD_POS   = 15,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [AW-1:0] listBase,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] curAddr,
  output dpStatus_t     stat
);

  localparam int PW = AW - PTR_LSB;

  logic [PW-1:0] curPtr;
  logic [PW-1:0] linkPtr;
  logic          reclQ;
  logic [PW-1:0] memPtr;

  assign memPtr  = memData[AW-1:PTR_LSB];
  assign curAddr = {curPtr, {PTR_LSB{1'b0}}};
  assign memAddr = curAddr + (strb.hiWord ? AW'(WORD_BYTES) : '0);

  logic unusedBits;
  assign unusedBits = ^{listBase[PTR_LSB-1:0], memData[PTR_LSB-1:3], memData[DW-1:AW]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr  <= '0;
      linkPtr <= '0;
      reclQ   <= 1'b0;
    end else begin
      if (strb.loadBase)       curPtr <= listBase[AW-1:PTR_LSB];
      else if (strb.stepMem)   curPtr <= memPtr;
      else if (strb.stepLatch) curPtr <= linkPtr;
      if (strb.latchLink) linkPtr <= memPtr;
      if (strb.setRecl)      reclQ <= 1'b1;
      else if (strb.clrRecl) reclQ <= 1'b0;
    end
  end

  assign stat.linkTerm = memData[0];
  assign stat.linkIsQh = (memData[2:1] == TYPE_QH);
  assign stat.headBit  = memData[HEAD_POS];
  assign stat.reclFlag = reclQ;

  AST_RECL_SET_ON_EXEC: assert property (@(posedge clk) disable iff (!rstN) strb.setRecl |=> stat.reclFlag); // R5
  AST_RECL_CLR_ON_HEAD: assert property (@(posedge clk) disable iff (!rstN) (strb.clrRecl && !strb.setRecl) |=> !stat.reclFlag); // R4

endmodule

// File: rtl/async_idle_ctrl.sv
module async_idle_ctrl
  import asedPkg::*;
#(
  parameter int UF_LEN   = 7500,
  parameter int MIN_LEFT = 600
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      schedEnable,
  input  logic      memValid,
  input  logic      txnExec,
  input  logic      uframeStart,
  input  logic      kickRestart,
  input  logic      doorbell,
  input  logic      clrAdvance,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      execReq,
  output logic      travActive,
  output logic      idle,
  output logic      asyncAdvSts
);

  localparam int LW = (UF_LEN > 2) ? $clog2(UF_LEN) : 1;

  walkState_e    state, nxt;
  logic [LW-1:0] ufLeft;
  logic          restartOk;
  logic          advPend, advSts, advDone;

  assign restartOk = (ufLeft >= LW'(MIN_LEFT));

  always_comb begin
    nxt  = state;
    strb = '0;
    if (!schedEnable) begin
      nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          strb.loadBase = 1'b1;
          strb.setRecl  = 1'b1;
          nxt           = ST_LINK;
        end
        ST_LINK: begin
          if (memValid) begin
            if (stat.linkTerm) begin
              nxt = ST_STOP;
            end else if (!stat.linkIsQh) begin
              strb.stepMem = 1'b1;
            end else begin
              strb.latchLink = 1'b1;
              nxt            = ST_HEAD;
            end
          end
        end
        ST_HEAD: begin
          strb.hiWord = 1'b1;
          if (memValid) begin
            if (stat.headBit && !stat.reclFlag) begin
              nxt = ST_STOP;
            end else begin
              strb.clrRecl = stat.headBit;
              nxt          = ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          strb.setRecl   = txnExec;
          strb.stepLatch = 1'b1;
          nxt            = ST_LINK;
        end
        ST_STOP: begin
          if (uframeStart || (kickRestart && restartOk)) begin
            strb.setRecl = 1'b1;
            nxt          = ST_LINK;
          end
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  assign memReq     = (state == ST_LINK) || (state == ST_HEAD);
  assign execReq    = (state == ST_EXEC);
  assign travActive = memReq || execReq;
  assign idle       = (state == ST_STOP);
  assign advDone    = advPend && (execReq || !travActive);
  assign asyncAdvSts = advSts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      ufLeft  <= '0;
      advPend <= 1'b0;
      advSts  <= 1'b0;
    end else begin
      state <= nxt;
      if (uframeStart)        ufLeft <= LW'(UF_LEN - 1);
      else if (ufLeft != '0)  ufLeft <= ufLeft - 1'b1;
      if (advDone) begin
        advSts  <= 1'b1;
        advPend <= 1'b0;
      end else begin
        if (clrAdvance) advSts <= 1'b0;
        if (doorbell && !advSts && !advPend) advPend <= 1'b1;
      end
    end
  end

  AST_ADV_STICKY:     assert property (@(posedge clk) disable iff (!rstN) (asyncAdvSts && !clrAdvance) |=> asyncAdvSts); // R12
  AST_ADV_NOT_ON_RING: assert property (@(posedge clk) disable iff (!rstN) (doorbell && !asyncAdvSts && !advPend) |=> !asyncAdvSts); // R11
  AST_RESTART_WINDOW: assert property (@(posedge clk) disable iff (!rstN) (idle && schedEnable && !uframeStart && (ufLeft < LW'(MIN_LEFT))) |=> idle); // R10
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN) !schedEnable |=> (!travActive && !idle)); // R13

endmodule

// File: rtl/async_idle_detect.sv
module async_idle_detect
  import asedPkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int UF_LEN   = 7500,
  parameter int MIN_LEFT = 600
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          schedEnable,
  input  logic [AW-1:0] listBase,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  input  logic          memValid,
  input  logic [DW-1:0] memData,
  output logic          execReq,
  output logic [AW-1:0] execQhAddr,
  input  logic          txnExec,
  input  logic          uframeStart,
  input  logic          kickRestart,
  input  logic          doorbell,
  input  logic          clrAdvance,
  output logic          reclFlag,
  output logic          travActive,
  output logic          idle,
  output logic          asyncAdvSts
);

  dpStrobe_t strb;
  dpStatus_t stat;

  async_idle_ctrl #(
    .UF_LEN  (UF_LEN),
    .MIN_LEFT(MIN_LEFT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .schedEnable(schedEnable),
    .memValid   (memValid),
    .txnExec    (txnExec),
    .uframeStart(uframeStart),
    .kickRestart(kickRestart),
    .doorbell   (doorbell),
    .clrAdvance (clrAdvance),
    .stat       (stat),
    .strb       (strb),
    .memReq     (memReq),
    .execReq    (execReq),
    .travActive (travActive),
    .idle       (idle),
    .asyncAdvSts(asyncAdvSts)
  );

  async_idle_dp #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .listBase(listBase),
    .memData (memData),
    .memAddr (memAddr),
    .curAddr (execQhAddr),
    .stat    (stat)
  );

  assign reclFlag = stat.reclFlag;

endmodule

// File: tb/async_idle_detect_bench.sv
`timescale 1ns/1ps
module async_idle_detect_bench;

  localparam int UF_LEN   = 200;
  localparam int MIN_LEFT = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        schedEnable = 1'b0;
  logic [31:0] listBase = '0;
  logic        memReq, memValid, execReq, txnExec = 1'b0;
  logic [31:0] memAddr, memData, execQhAddr;
  logic        uframeStart = 1'b0, kickRestart = 1'b0, doorbell = 1'b0, clrAdvance = 1'b0;
  logic        reclFlag, travActive, idle, asyncAdvSts;

  logic [31:0] mem [0:63];
  int addrLog [0:4095];
  int offerCnt = 0, startCnt = 0, budget = 0, ufEdges = 0;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  assign memValid = memReq;
  assign memData  = mem[memAddr[7:2]];

  async_idle_detect #(.UF_LEN(UF_LEN), .MIN_LEFT(MIN_LEFT)) u_async_idle_detect (
    .clk(clk), .rstN(rstN), .schedEnable(schedEnable), .listBase(listBase),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .execReq(execReq), .execQhAddr(execQhAddr), .txnExec(txnExec),
    .uframeStart(uframeStart), .kickRestart(kickRestart), .doorbell(doorbell),
    .clrAdvance(clrAdvance), .reclFlag(reclFlag), .travActive(travActive),
    .idle(idle), .asyncAdvSts(asyncAdvSts)
  );

  // stub engine: log offers, run a transaction while under budget
  always @(negedge clk) begin
    if (rstN && execReq) begin
      if (offerCnt < 4096) addrLog[offerCnt] = int'(execQhAddr);
      txnExec <= ((offerCnt - startCnt) < budget);
      offerCnt = offerCnt + 1;
    end else begin
      txnExec <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (uframeStart) ufEdges <= 0;
    else             ufEdges <= ufEdges + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  // ring of n queue heads at i*32, mark on index 0
  task automatic buildRing(input int n);
    clearMem();
    for (int i = 0; i < n; i++) begin
      mem[i*8]     = 32'(((i + 1) % n) * 32) | 32'h2;
      mem[i*8 + 1] = (i == 0) ? 32'h0000_8000 : 32'h0;
    end
  endtask

  task automatic waitIdle();
    int g = 0;
    while (!idle && g < 4000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic runList(input int b, input int m, output int got);
    schedEnable = 1'b0;
    repeat (2) @(negedge clk);
    listBase = 32'(b * 32);
    startCnt = offerCnt;
    budget   = m;
    schedEnable = 1'b1;
    @(negedge clk);
    chk(reclFlag == 1'b1, "R3 flag set when walk starts", int'(reclFlag), 1);
    waitIdle();
    got = offerCnt - startCnt;
  endtask

  function automatic int expOffers(input int n, input int b, input int m);
    int pre = (n - b) % n;
    int j = 1;
    while (pre + (j - 1) * n < m) j++;
    return pre + j * n;
  endfunction

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int got, bad, base0;
    clearMem();
    repeat (3) @(negedge clk);
    chk({reclFlag, travActive, idle, asyncAdvSts, memReq, execReq} == 6'b0, "R1 reset outputs",
        int'({reclFlag, travActive, idle, asyncAdvSts, memReq, execReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({reclFlag, travActive, idle, asyncAdvSts} == 4'b0, "R1 outputs after release",
        int'({reclFlag, travActive, idle, asyncAdvSts}), 0);

    // sweep: ring size, start index, transaction budget (R2 R4 R5 R6)
    for (int n = 1; n <= 4; n++) begin
      for (int b = 0; b < n; b++) begin
        for (int s = 0; s < 5; s++) begin
          int m;
          case (s)
            0: m = 0;
            1: m = 1;
            2: m = n;
            3: m = n + 1;
            default: m = 2 * n + 1;
          endcase
          buildRing(n);
          runList(b, m, got);
          chk(got == expOffers(n, b, m), "R6 offers before stop", got, expOffers(n, b, m));
          bad = 0;
          for (int k = 0; k < got; k++)
            if (addrLog[startCnt + k] != ((b + k) % n) * 32) bad++;
          chk(bad == 0, "R2 offer address order", bad, 0);
          chk(reclFlag == 1'b0 && travActive == 1'b0, "R4 flag clear and walk halted",
              int'({reclFlag, travActive}), 0);
        end
      end
    end

    // restart from stop position, not from base (R9)
    buildRing(3);
    runList(1, 0, got);
    chk(got == 5, "R6 lead-in plus one lap", got, 5);
    uframeStart = 1'b1;
    @(negedge clk);
    uframeStart = 1'b0;
    chk(reclFlag == 1'b1 && idle == 1'b0, "R9 restart sets flag", int'({reclFlag, idle}), 2);
    base0 = offerCnt;
    waitIdle();
    chk(offerCnt - base0 == 3, "R9 offers after restart", offerCnt - base0, 3);
    chk(addrLog[base0] == 0, "R9 restart resumes at marked entry", addrLog[base0], 0);

    // kick with MIN_LEFT-1 cycles left: ignored (R10)
    while (ufEdges != UF_LEN - MIN_LEFT) @(negedge clk);
    base0 = offerCnt;
    pulse(kickRestart);
    repeat (4) @(negedge clk);
    chk(idle == 1'b1 && offerCnt == base0, "R10 late kick ignored", offerCnt - base0, 0);

    // kick with exactly MIN_LEFT cycles left: accepted (R10)
    pulse(uframeStart);
    waitIdle();
    while (ufEdges != UF_LEN - 1 - MIN_LEFT) @(negedge clk);
    base0 = offerCnt;
    pulse(kickRestart);
    chk(idle == 1'b0, "R10 kick at threshold restarts", int'(idle), 0);
    waitIdle();
    chk(offerCnt - base0 == 3, "R10 offers after kick", offerCnt - base0, 3);

    // non queue head entry skipped (R7)
    clearMem();
    mem[0]  = 32'd160 | 32'h2;  mem[1]  = 32'h0000_8000;
    mem[40] = 32'd32;                                     // type 00 at 160
    mem[8]  = 32'd64 | 32'h2;
    mem[16] = 32'd0 | 32'h2;
    runList(0, 0, got);
    chk(got == 3, "R7 skipped entry not offered", got, 3);
    bad = 0;
    for (int k = 0; k < got; k++) if (addrLog[startCnt + k] != k * 32) bad++;
    chk(bad == 0, "R7 walk follows skipped link", bad, 0);

    // terminate stops (R8)
    clearMem();
    mem[0] = 32'd32 | 32'h3;
    runList(0, 0, got);
    chk(got == 0 && idle == 1'b1, "R8 terminate halts walk", got, 0);

    // doorbell while off (R11, R12)
    schedEnable = 1'b0;
    repeat (2) @(negedge clk);
    pulse(doorbell);
    chk(asyncAdvSts == 1'b0, "R11 not set on doorbell edge", int'(asyncAdvSts), 0);
    @(negedge clk);
    chk(asyncAdvSts == 1'b1, "R11 set one cycle later when off", int'(asyncAdvSts), 1);
    pulse(doorbell);
    repeat (2) @(negedge clk);
    chk(asyncAdvSts == 1'b1, "R12 status sticky", int'(asyncAdvSts), 1);
    pulse(clrAdvance);
    repeat (3) @(negedge clk);
    chk(asyncAdvSts == 1'b0, "R12 doorbell while set ignored", int'(asyncAdvSts), 0);

    // doorbell during an active walk (R11)
    buildRing(4);
    startCnt = offerCnt;
    budget = 1000;
    listBase = '0;
    schedEnable = 1'b1;
    repeat (7) @(negedge clk);
    pulse(doorbell);
    chk(asyncAdvSts == 1'b0, "R11 not set on doorbell edge while active", int'(asyncAdvSts), 0);
    repeat (3) @(negedge clk);
    chk(asyncAdvSts == 1'b1 && travActive == 1'b1, "R11 set after offer completes",
        int'({asyncAdvSts, travActive}), 3);
    pulse(clrAdvance);
    chk(asyncAdvSts == 1'b0, "R12 clear pulse", int'(asyncAdvSts), 0);

    // disable mid-walk (R13)
    schedEnable = 1'b0;
    @(negedge clk);
    chk({travActive, idle, memReq} == 3'b0, "R13 disable stops walk",
        int'({travActive, idle, memReq}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule